// File: doc/BRIEF.md
# Flash Update Controller

This block sits in the register space of a network card and lets host software reprogram one of two serial flash devices: the configuration flash of the programmable logic (chip 0) or the firmware flash of the on-card processor (chip 1). Software first enables update mode. It then picks a target chip and an operation through a flash-mode register and, for a write, loads a block number. It stages the block's bytes in a shared buffer RAM and fires a trigger register. The block then erases the whole selected chip, or streams one block from the staging RAM to the flash through a simple request/acknowledge byte port.

The two chips have different page sizes but share one command encoding. A block is always a fixed number of pages, so the block size and the flash byte address both depend on the selected chip. Each staged 32-bit word carries four stream bytes in a swapped byte-lane order, which the block undoes before sending bytes. A busy flag covers the whole operation, and a sticky, enable-gated interrupt marks its end. Software waits for that interrupt and a busy read of 0, then clears the trigger and prepares the next block. A short last block is padded with zero lanes by software, because the block always sends a full block.

Top module: `flash_update_ctrl`

## Requirements
- R1: After reset every register reads 0, busy_o and irq_o are 0, and no flash request is raised.
- R2: The flash-mode register (offset 0x58, bits 1:0) holds chip×2 + op. Op 0 erases the whole chip and issues exactly one request with fl_cmd_o=0. Op 1 writes one block with fl_cmd_o=1 per byte. fl_chip_o carries the chip bit on every request.
- R3: An operation starts only on a write of 1 to the trigger register (offset 0x6C, bit 0) while that register holds 0, update mode (offset 0x5C, bit 0) is 1 and busy is 0. A trigger in data mode, or a rewrite of 1, starts nothing.
- R4: A block write sends PAGE_B×PAGES_PER_BLK bytes (528×8 for chip 0 and 512×8 for chip 1 by default). Byte i goes to flash address block×block_size + i, where the block number is offset 0x64.
- R5: Stream byte i comes from staging word i/4, lane i%4. Lane 0 is bits 15:8, lane 1 bits 7:0, lane 2 bits 31:24 and lane 3 bits 23:16.
- R6: busy_o, which also reads at offset 0x60 bit 0, rises in the cycle after the accepted trigger write. It stays 1 until the cycle after the final acknowledge.
- R7: Completion sets a sticky flag that reads at offset 0x70 bit 0. irq_o equals this flag ANDed with the enable register (offset 0x78, bit 0).
- R8: Any write to offset 0x70 clears the flag. If a completion occurs in the same cycle, the flag stays set.
- R9: Writes to the block-number and flash-mode registers while busy is 1 are ignored.
- R10: A request holds its command, address and data stable until it is acknowledged. Every byte of the block is delivered exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| busy_o | output | 1 | Operation in progress |
| irq_o | output | 1 | Completion interrupt |
| stg_rd_o | output | 1 | Staging RAM read strobe |
| stg_addr_o | output | STG_AW | Staging RAM word address |
| stg_rdata_i | input | 32 | Staging RAM data, one cycle after the read |
| fl_req_o | output | 1 | Flash command request |
| fl_cmd_o | output | 1 | 0 erase chip, 1 program byte |
| fl_chip_o | output | 1 | Target chip |
| fl_addr_o | output | ADDR_W | Flash byte address |
| fl_data_o | output | 8 | Byte to program |
| fl_ack_i | input | 1 | Request accepted this cycle |

## Verification
The final flash acknowledge of an operation and a host write to the interrupt-clear offset can land in the same clock: one tries to set the sticky flag while the other clears it. The bench's flash model provokes this collision itself. When it grants the last queued byte, it drives the clear write in that same cycle. The reference model then expects irq_o and the flag read to stay 1. A separate step clears the flag with no completion pending and expects it to drop to 0.

// File: rtl/flu_pkg.sv
package flu_pkg;
  localparam logic [7:0] OFS_FMODE = 8'h58;
  localparam logic [7:0] OFS_UPD   = 8'h5C;
  localparam logic [7:0] OFS_BUSY  = 8'h60;
  localparam logic [7:0] OFS_BLK   = 8'h64;
  localparam logic [7:0] OFS_TRIG  = 8'h6C;
  localparam logic [7:0] OFS_ICLR  = 8'h70;
  localparam logic [7:0] OFS_IEN   = 8'h78;

  localparam logic CMD_ERASE = 1'b0;
  localparam logic CMD_PROG  = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ERASE,
    ST_FETCH,
    ST_LOAD,
    ST_SEND
  } seq_st_e;
endpackage

// File: rtl/flu_unpack.sv
module flu_unpack (
  input  logic [31:0] word_i,
  input  logic [1:0]  lane_i,
  output logic [7:0]  byte_o
);
  // staged words carry the stream in a swapped lane order
  always_comb begin
    unique case (lane_i)
      2'd0: byte_o = word_i[15:8];
      2'd1: byte_o = word_i[7:0];
      2'd2: byte_o = word_i[31:24];
      default: byte_o = word_i[23:16];
    endcase
  end
endmodule

// File: rtl/flu_regs.sv
module flu_regs
  import flu_pkg::*;
#(
  parameter int BLK_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  output logic             start_o,
  output logic             chip_o,
  output logic             op_o,
  output logic [BLK_W-1:0] blk_o,
  output logic             irq_o
);
  logic             upd_q, trig_q, ien_q, iflag_q;
  logic [1:0]       fmode_q;
  logic [BLK_W-1:0] blk_q;
  logic wr_upd, wr_trig, wr_ien, wr_iclr, wr_fmode, wr_blk;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i[31:BLK_W];

  assign wr_upd   = wr_i && (addr_i == OFS_UPD);
  assign wr_trig  = wr_i && (addr_i == OFS_TRIG);
  assign wr_ien   = wr_i && (addr_i == OFS_IEN);
  assign wr_iclr  = wr_i && (addr_i == OFS_ICLR);
  assign wr_fmode = wr_i && (addr_i == OFS_FMODE);
  assign wr_blk   = wr_i && (addr_i == OFS_BLK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q   <= 1'b0;
      trig_q  <= 1'b0;
      ien_q   <= 1'b0;
      iflag_q <= 1'b0;
      fmode_q <= '0;
      blk_q   <= '0;
    end else begin
      if (wr_upd)  upd_q  <= wdata_i[0];
      if (wr_trig) trig_q <= wdata_i[0];
      if (wr_ien)  ien_q  <= wdata_i[0];
      // operation parameters are frozen while busy
      if (wr_fmode && !busy_i) fmode_q <= wdata_i[1:0];
      if (wr_blk && !busy_i)   blk_q   <= wdata_i[BLK_W-1:0];
      // completion has priority over a clear in the same cycle
      if (done_i)       iflag_q <= 1'b1;
      else if (wr_iclr) iflag_q <= 1'b0;
    end
  end

  assign start_o = wr_trig && wdata_i[0] && !trig_q && upd_q && !busy_i;
  assign chip_o  = fmode_q[1];
  assign op_o    = fmode_q[0];
  assign blk_o   = blk_q;
  assign irq_o   = iflag_q & ien_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_UPD:   rdata_o = 32'(upd_q);
      OFS_TRIG:  rdata_o = 32'(trig_q);
      OFS_IEN:   rdata_o = 32'(ien_q);
      OFS_ICLR:  rdata_o = 32'(iflag_q);
      OFS_FMODE: rdata_o = 32'(fmode_q);
      OFS_BLK:   rdata_o = 32'(blk_q);
      OFS_BUSY:  rdata_o = 32'(busy_i);
      default:   rdata_o = '0;
    endcase
  end

  p_hold_blk_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_blk) |=> $stable(blk_o));
  p_hold_fmode_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_fmode) |=> $stable({chip_o, op_o}));
  p_done_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> iflag_q);
  p_start_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> busy_i);
endmodule

// File: rtl/flu_seq.sv
module flu_seq
  import flu_pkg::*;
#(
  parameter int BLK_W  = 12,
  parameter int ADDR_W = 24,
  parameter int BLK_B0 = 4224,
  parameter int BLK_B1 = 4096,
  parameter int CNT_W  = 13,
  localparam int STG_AW = CNT_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              chip_i,
  input  logic              op_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              stg_rd_o,
  output logic [STG_AW-1:0] stg_addr_o,
  input  logic [31:0]       stg_rdata_i,
  output logic              fl_req_o,
  output logic              fl_cmd_o,
  output logic              fl_chip_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_data_o,
  input  logic              fl_ack_i
);
  seq_st_e           state_q;
  logic              chip_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       word_q;
  logic [CNT_W-1:0]  last_idx;
  logic              last_byte;

  assign last_idx  = chip_q ? CNT_W'(BLK_B1 - 1) : CNT_W'(BLK_B0 - 1);
  assign last_byte = (cnt_q == last_idx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      chip_q  <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
      word_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          chip_q  <= chip_i;
          base_q  <= ADDR_W'(blk_i) * ADDR_W'(chip_i ? BLK_B1 : BLK_B0);
          cnt_q   <= '0;
          state_q <= op_i ? ST_FETCH : ST_ERASE;
        end
        ST_ERASE: if (fl_ack_i) state_q <= ST_IDLE;
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          word_q  <= stg_rdata_i;
          state_q <= ST_SEND;
        end
        ST_SEND: if (fl_ack_i) begin
          cnt_q <= cnt_q + CNT_W'(1);
          if (last_byte)              state_q <= ST_IDLE;
          else if (cnt_q[1:0] == 2'd3) state_q <= ST_FETCH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  flu_unpack u_unpack (
    .word_i (word_q),
    .lane_i (cnt_q[1:0]),
    .byte_o (fl_data_o)
  );

  assign busy_o     = (state_q != ST_IDLE);
  assign stg_rd_o   = (state_q == ST_FETCH);
  assign stg_addr_o = cnt_q[CNT_W-1:2];
  assign fl_req_o   = (state_q == ST_ERASE) || (state_q == ST_SEND);
  assign fl_cmd_o   = (state_q == ST_SEND) ? CMD_PROG : CMD_ERASE;
  assign fl_chip_o  = chip_q;
  assign fl_addr_o  = base_q + ADDR_W'(cnt_q);
  assign done_o     = fl_ack_i && ((state_q == ST_ERASE) ||
                                   ((state_q == ST_SEND) && last_byte));

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && !fl_ack_i) |=> (fl_req_o && $stable(fl_addr_o) &&
                                 $stable(fl_data_o) && $stable(fl_cmd_o)));
  p_busy_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_fetch_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stg_rd_o |=> !fl_req_o);
  p_addr_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_req_o && fl_ack_i && (fl_cmd_o == CMD_PROG) && !done_o)
      |=> (fl_addr_o == $past(fl_addr_o) + ADDR_W'(1)));
endmodule

// File: rtl/flash_update_ctrl.sv
module flash_update_ctrl
  import flu_pkg::*;
#(
  parameter int PAGE_B0       = 528,
  parameter int PAGE_B1       = 512,
  parameter int PAGES_PER_BLK = 8,
  parameter int BLK_W         = 12,
  parameter int ADDR_W        = 24,
  localparam int BLK_B0  = PAGE_B0 * PAGES_PER_BLK,
  localparam int BLK_B1  = PAGE_B1 * PAGES_PER_BLK,
  localparam int BLK_MAX = (BLK_B0 > BLK_B1) ? BLK_B0 : BLK_B1,
  localparam int CNT_W   = $clog2(BLK_MAX),
  localparam int STG_AW  = CNT_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              busy_o,
  output logic              irq_o,
  output logic              stg_rd_o,
  output logic [STG_AW-1:0] stg_addr_o,
  input  logic [31:0]       stg_rdata_i,
  output logic              fl_req_o,
  output logic              fl_cmd_o,
  output logic              fl_chip_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [7:0]        fl_data_o,
  input  logic              fl_ack_i
);
  logic             start, chip, op, done, busy;
  logic [BLK_W-1:0] blk;

  flu_regs #(.BLK_W(BLK_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .busy_i  (busy),
    .done_i  (done),
    .start_o (start),
    .chip_o  (chip),
    .op_o    (op),
    .blk_o   (blk),
    .irq_o   (irq_o)
  );

  flu_seq #(
    .BLK_W  (BLK_W),
    .ADDR_W (ADDR_W),
    .BLK_B0 (BLK_B0),
    .BLK_B1 (BLK_B1),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .chip_i      (chip),
    .op_i        (op),
    .blk_i       (blk),
    .busy_o      (busy),
    .done_o      (done),
    .stg_rd_o    (stg_rd_o),
    .stg_addr_o  (stg_addr_o),
    .stg_rdata_i (stg_rdata_i),
    .fl_req_o    (fl_req_o),
    .fl_cmd_o    (fl_cmd_o),
    .fl_chip_o   (fl_chip_o),
    .fl_addr_o   (fl_addr_o),
    .fl_data_o   (fl_data_o),
    .fl_ack_i    (fl_ack_i)
  );

  assign busy_o = busy;
endmodule

// File: tb/tb_flash_update_ctrl.sv
module tb_flash_update_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int P0 = 12, P1 = 8, PG = 2;
  localparam int B0 = P0 * PG, B1 = P1 * PG;
  localparam int AW = 24, SAW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic t_wr = 1'b0, coll_wr = 1'b0;
  logic [7:0] t_addr = '0;
  logic [31:0] t_wdata = '0;
  logic reg_wr;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata, stg_rdata;
  logic busy, irq, stg_rd, fl_req, fl_cmd, fl_chip, fl_ack = 1'b0;
  logic [SAW-1:0] stg_addr;
  logic [AW-1:0] fl_addr;
  logic [7:0] fl_data;
  logic [31:0] ram [8];

  int total = 0, fails = 0;
  logic [33:0] expq[$];
  bit m_upd, m_trig, m_ien, m_flag, exp_busy, coll_arm;
  logic [1:0] m_fmode;
  int m_blk, ack_dly, wcnt, n_acks;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign reg_wr    = t_wr | coll_wr;
  assign reg_addr  = coll_wr ? 8'h70 : t_addr;
  assign reg_wdata = coll_wr ? 32'h0 : t_wdata;

  always @(posedge clk) stg_rdata <= ram[stg_addr];

  flash_update_ctrl #(.PAGE_B0(P0), .PAGE_B1(P1), .PAGES_PER_BLK(PG),
                      .BLK_W(12), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .busy_o(busy),
    .irq_o(irq), .stg_rd_o(stg_rd), .stg_addr_o(stg_addr),
    .stg_rdata_i(stg_rdata), .fl_req_o(fl_req), .fl_cmd_o(fl_cmd),
    .fl_chip_o(fl_chip), .fl_addr_o(fl_addr), .fl_data_o(fl_data),
    .fl_ack_i(fl_ack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lane_shift(input int lane);
    case (lane)
      0: return 8;
      1: return 0;
      2: return 24;
      default: return 16;
    endcase
  endfunction

  task automatic build_queue(input logic [1:0] fm, input int blk);
    int len, base;
    logic [7:0] b;
    if (!fm[0]) expq.push_back({1'b0, fm[1], 24'h0, 8'h0});
    else begin
      len  = fm[1] ? B1 : B0;
      base = blk * len;
      for (int i = 0; i < len; i++) begin
        b = 8'((ram[i/4] >> lane_shift(i % 4)) & 32'hFF);
        expq.push_back({1'b1, fm[1], 24'(base + i), b});
      end
    end
  endtask

  // reference model, evaluated once per clock between edges
  initial begin
    logic [33:0] e;
    bit last, start, ew;
    logic [7:0] ea;
    logic [31:0] ed;
    forever begin
      @(negedge clk);
      if (!rst_n) continue;
      chk(busy == exp_busy, "R6 busy", busy, exp_busy);
      chk(irq == (m_flag & m_ien), "R7 irq", irq, m_flag & m_ien);
      if (fl_req && expq.size() == 0) chk(1'b0, "R3 unexpected request", 1, 0);
      last = 0;
      coll_wr = 1'b0;
      if (fl_req && expq.size() > 0 && wcnt >= ack_dly) begin
        fl_ack = 1'b1;
        wcnt = 0;
        n_acks++;
        e = expq.pop_front();
        chk(fl_cmd == e[33], "R2 command", fl_cmd, e[33]);
        chk(fl_chip == e[32], "R2 chip", fl_chip, e[32]);
        if (e[33]) begin
          chk(fl_addr == e[31:8], "R4 address", fl_addr, e[31:8]);
          chk(fl_data == e[7:0], "R5 byte", fl_data, e[7:0]);
        end
        if (expq.size() == 0) begin
          last = 1;
          if (coll_arm) begin coll_wr = 1'b1; coll_arm = 0; end
        end
      end else begin
        fl_ack = 1'b0;
        if (fl_req) wcnt++;
      end
      ew = t_wr | coll_wr;
      ea = coll_wr ? 8'h70 : t_addr;
      ed = coll_wr ? 32'h0 : t_wdata;
      start = ew && ea == 8'h6C && ed[0] && !m_trig && m_upd && !exp_busy;
      if (start) build_queue(m_fmode, m_blk);
      if (ew) begin
        case (ea)
          8'h5C: m_upd = ed[0];
          8'h6C: m_trig = ed[0];
          8'h78: m_ien = ed[0];
          8'h58: if (!exp_busy) m_fmode = ed[1:0];
          8'h64: if (!exp_busy) m_blk = int'(ed[11:0]);
          default: ;
        endcase
      end
      if (last) m_flag = 1;
      else if (ew && ea == 8'h70) m_flag = 0;
      if (start) exp_busy = 1;
      else if (last) exp_busy = 0;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    t_wr = 1'b1; t_addr = a; t_wdata = d;
    @(posedge clk); #1;
    t_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input int exp, input string tag);
    @(posedge clk); #1;
    t_addr = a;
    @(negedge clk);
    chk(reg_rdata == 32'(exp), tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (exp_busy || busy || expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL R6 watchdog act=hung exp=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n0;
    ack_dly = 2;
    for (int i = 0; i < 8; i++) ram[i] = 32'hA1B2C3D4 + 32'(i) * 32'h11110101;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    // R1: reset values
    rd(8'h5C, 0, "R1 update mode reset");
    rd(8'h58, 0, "R1 flash mode reset");
    rd(8'h64, 0, "R1 block reset");
    rd(8'h6C, 0, "R1 trigger reset");
    rd(8'h60, 0, "R1 busy reset");
    rd(8'h70, 0, "R1 flag reset");
    chk(!fl_req && !irq, "R1 outputs idle", {fl_req, irq}, 0);
    wr(8'h78, 1);
    // R3: trigger in data mode ignored
    wr(8'h58, 2);
    wr(8'h6C, 1);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R3 data-mode trigger ignored", busy, 0);
    wr(8'h6C, 0);
    // R2: chip 1 erase
    wr(8'h5C, 1);
    rd(8'h5C, 1, "R3 update mode set");
    wr(8'h6C, 1);
    wait_idle();
    rd(8'h70, 1, "R7 flag after erase");
    chk(irq == 1, "R7 irq after erase", irq, 1);
    wr(8'h70, 0);
    chk(irq == 0, "R8 clear drops irq", irq, 0);
    // R3: rewrite of 1 does not restart
    wr(8'h6C, 1);
    repeat (4) @(negedge clk);
    chk(busy == 0, "R3 rewrite of one ignored", busy, 0);
    wr(8'h6C, 0);
    // R4/R5/R9: chip 0 write, block 3
    wr(8'h58, 1);
    wr(8'h64, 3);
    n0 = n_acks;
    wr(8'h6C, 1);
    repeat (5) @(posedge clk);
    wr(8'h64, 7);
    wr(8'h58, 2);
    rd(8'h64, 3, "R9 block held while busy");
    rd(8'h58, 1, "R9 mode held while busy");
    rd(8'h60, 1, "R6 busy reads one");
    wait_idle();
    chk(n_acks - n0 == B0, "R10 all bytes delivered chip0", n_acks - n0, B0);
    wr(8'h70, 0);
    wr(8'h6C, 0);
    // R8: completion collides with clear; chip 1 write, block 5
    for (int i = 0; i < 8; i++) ram[i] = 32'h0F1E2D3C ^ (32'(i) << 4);
    ack_dly = 1;
    wr(8'h58, 3);
    wr(8'h64, 5);
    coll_arm = 1;
    n0 = n_acks;
    wr(8'h6C, 1);
    wait_idle();
    chk(n_acks - n0 == B1, "R10 all bytes delivered chip1", n_acks - n0, B1);
    chk(irq == 1, "R8 completion beats clear", irq, 1);
    rd(8'h70, 1, "R8 flag kept");
    // R7: enable gates irq
    wr(8'h78, 0);
    chk(irq == 0, "R7 irq gated off", irq, 0);
    rd(8'h70, 1, "R7 flag still set");
    wr(8'h78, 1);
    chk(irq == 1, "R7 irq regated", irq, 1);
    wr(8'h70, 0);
    wr(8'h6C, 0);
    // R2: chip 0 erase with zero-delay ack
    ack_dly = 0;
    wr(8'h58, 0);
    wr(8'h6C, 1);
    wait_idle();
    rd(8'h70, 1, "R2 chip0 erase done");
    wr(8'h70, 0);
    wr(8'h6C, 0);
    // R3: back to data mode, trigger ignored
    wr(8'h5C, 0);
    rd(8'h5C, 0, "R3 data mode restored");
    wr(8'h6C, 1);
    repeat (4) @(negedge clk);
    chk(busy == 0 && expq.size() == 0, "R3 trigger after return ignored", busy, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule